// File: doc/BRIEF.md
# Serial Bit Transmit Queue with Bit-Rate Generator

This block holds transmit data one bit per entry and presents it, oldest first, on a serial output that feeds a modulator. A host writes single bits with a strobe while the queue is enabled. Once both the queue enable and the transmit enable are high, an internal bit-rate generator produces a one-cycle tick at a programmable rate. Each tick removes one stored bit and drives it onto the serial output.

The rate generator divides the block clock by a fixed prescale of 29 and then by (R+1), with a further factor of 8 when the slow-range select is set. The block also reports three status flags. One shows that the stored-bit count has fallen to a programmable 6-bit level or below. One shows that the queue is empty. One is a sticky overflow flag that a status read clears.

Top module: `bitfifo_tx`

## Requirements
- R1: After synchronous reset: `empty_flag`=1, `lvl_flag`=1, `ovf_flag`=0, `ser_out`=0 and `bit_tick`=0.
- R2: While `fifo_en`=1, each cycle with `wr_stb`=1 stores `wr_bit`, provided fewer than 64 bits are held. Bits leave in write order, one per `bit_tick`, and `ser_out` takes the removed bit on the clock edge that ends the tick cycle.
- R3: While `fifo_en`=0 the stored bits are discarded, so `empty_flag`=1 one cycle later. Write strobes are ignored while `fifo_en`=0.
- R4: Capacity is 64 bits. A write while 64 bits are held is not stored, even if a tick removes a bit in the same cycle, and it sets `ovf_flag`.
- R5: `ovf_flag` stays set until a cycle with `stat_rd`=1. A new overflow in the same cycle as `stat_rd` keeps it set.
- R6: `lvl_flag`=1 exactly when the stored-bit count is less than or equal to the unsigned 6-bit `thresh`. It follows `thresh` combinationally.
- R7: `empty_flag`=1 exactly when no bits are stored.
- R8: `bit_tick` is high only while `fifo_en` and `tx_en` are both 1. It is one cycle wide and repeats every P = 29·(`rate_r`+1)·(`rate_cs` ? 8 : 1) cycles. When the enables go high, the first tick is seen at the P-th rising edge, counting the first edge at which they are high as 1. Clearing either enable restarts the count.
- R9: A tick while the queue is empty removes nothing, and `ser_out` keeps its last value.
- R10: A write and a tick in the same cycle, with between 1 and 63 bits held, both take effect, so the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Queue enable; low discards contents |
| wr_stb | input | 1 | Write strobe for one bit |
| wr_bit | input | 1 | Bit value to store |
| thresh | input | 6 | Level for the low-fill flag |
| tx_en | input | 1 | Transmit enable; starts the rate generator |
| rate_r | input | 7 | Rate divisor minus one |
| rate_cs | input | 1 | Slow-range select (extra divide by 8) |
| stat_rd | input | 1 | Status read strobe; clears overflow |
| ser_out | output | 1 | Serial data to the modulator |
| bit_tick | output | 1 | One-cycle bit-rate pulse |
| lvl_flag | output | 1 | Count at or below `thresh` |
| empty_flag | output | 1 | No bits stored |
| ovf_flag | output | 1 | Sticky overflow |

## Verification
The fill count, the empty flag and the overflow flag change on the edge that takes a write or a tick, so they are due one cycle after the stimulus. `lvl_flag` also follows `thresh` with no delay. `ser_out` changes on the edge that ends the tick cycle. The first tick arrives P edges after the enables rise, and later ticks arrive every P cycles. All inputs change 2 ns after a rising edge, and outputs are compared either at the next such point or at the falling edge against a bit queue kept by the bench. The tick check uses a cycle counter that restarts whenever the enables drop.

// File: rtl/bitfifo_pkg.sv
`timescale 1ns/1ps
package bitfifo_pkg;

    localparam int unsigned BF_DEPTH       = 64;
    localparam int unsigned BF_THR_W       = 6;
    localparam int unsigned BF_RATE_W      = 7;
    localparam int unsigned BF_PRESCALE    = 29;
    localparam int unsigned BF_SLOW_SHIFT  = 3;

    typedef enum logic {
        BF_RATE_X1 = 1'b0,
        BF_RATE_X8 = 1'b1
    } bf_rate_e;

    typedef struct packed {
        logic clear;
        logic push;
        logic pop;
        logic drop;
    } bf_op_t;

    function automatic logic bf_at_or_below(input int unsigned cnt, input int unsigned lvl);
        return cnt <= lvl;
    endfunction

endpackage

// File: rtl/bitfifo_rate_gen.sv
`timescale 1ns/1ps
module bitfifo_rate_gen
    import bitfifo_pkg::*;
#(
    parameter int unsigned PRESCALE   = BF_PRESCALE,
    parameter int unsigned RATE_W     = BF_RATE_W,
    parameter int unsigned SLOW_SHIFT = BF_SLOW_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [RATE_W-1:0] rate_r,
    input  logic              rate_cs,
    output logic              tick
);
    localparam int unsigned PRE_W = $clog2(PRESCALE);
    localparam int unsigned DIV_W = RATE_W + SLOW_SHIFT;

    logic [PRE_W-1:0] pre_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] base;
    logic [DIV_W-1:0] lim_m1;
    logic             pre_last;
    logic             div_last;
    bf_rate_e         range;

    always_comb begin
        range = bf_rate_e'(rate_cs);
        base  = DIV_W'(rate_r) + DIV_W'(1);
        if (range == BF_RATE_X8)
            lim_m1 = (base << SLOW_SHIFT) - DIV_W'(1);
        else
            lim_m1 = base - DIV_W'(1);
    end

    assign pre_last = (pre_q == PRE_W'(PRESCALE - 1));
    assign div_last = (div_q >= lim_m1);
    assign tick     = run && pre_last && div_last;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
            div_q <= '0;
        end else if (pre_last) begin
            pre_q <= '0;
            div_q <= div_last ? '0 : div_q + DIV_W'(1);
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // R8: the tick is a single-cycle pulse
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R8: a stopped generator restarts from zero
    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        !run |=> !tick);

endmodule

// File: rtl/bitfifo_store.sv
`timescale 1ns/1ps
module bitfifo_store
    import bitfifo_pkg::*;
#(
    parameter int unsigned DEPTH = BF_DEPTH,
    parameter int unsigned CNT_W = $clog2(BF_DEPTH + 1),
    parameter int unsigned PTR_W = $clog2(BF_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  bf_op_t           op,
    input  logic             wr_bit,
    output logic [CNT_W-1:0] count,
    output logic             ser_out
);
    logic [DEPTH-1:0] cells;
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [PTR_W-1:0] wp_nx, rp_nx;
    logic [CNT_W-1:0] cnt_q;
    logic             ser_q;

    generate
        if ((1 << PTR_W) == DEPTH) begin : g_pow2_wrap
            assign wp_nx = wp_q + PTR_W'(1);
            assign rp_nx = rp_q + PTR_W'(1);
        end else begin : g_cmp_wrap
            assign wp_nx = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + PTR_W'(1);
            assign rp_nx = (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + PTR_W'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (op.push)
            cells[wp_q] <= wr_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ser_q <= 1'b0;
        end else if (op.clear) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (op.push)
                wp_q <= wp_nx;
            if (op.pop) begin
                rp_q  <= rp_nx;
                ser_q <= cells[rp_q];
            end
            case ({op.push, op.pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign count   = cnt_q;
    assign ser_out = ser_q;

    // R4: count never passes the capacity
    a_r4_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));

    // R3: a clear empties the store on the next edge
    a_r3_clear: assert property (@(posedge clk) disable iff (rst)
        op.clear |=> (cnt_q == '0));

    // R9: output changes only on a removal
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !op.pop |=> $stable(ser_q));

    // R10: simultaneous push and pop keep the count
    a_r10_both: assert property (@(posedge clk) disable iff (rst)
        (op.push && op.pop && !op.clear) |=> $stable(cnt_q));

endmodule

// File: rtl/bitfifo_flags.sv
`timescale 1ns/1ps
module bitfifo_flags
    import bitfifo_pkg::*;
#(
    parameter int unsigned CNT_W = $clog2(BF_DEPTH + 1),
    parameter int unsigned THR_W = BF_THR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [THR_W-1:0] thresh,
    input  logic             drop,
    input  logic             stat_rd,
    output logic             lvl_flag,
    output logic             empty_flag,
    output logic             ovf_flag
);
    logic ovf_q;

    always_ff @(posedge clk) begin
        if (rst)
            ovf_q <= 1'b0;
        else if (drop)
            ovf_q <= 1'b1;
        else if (stat_rd)
            ovf_q <= 1'b0;
    end

    assign lvl_flag   = bf_at_or_below(int'(count), int'(thresh));
    assign empty_flag = (count == '0);
    assign ovf_flag   = ovf_q;

    // R5: overflow stays until a status read
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !stat_rd) |=> ovf_q);

    // R5: a dropped write always leaves the flag set
    a_r5_set: assert property (@(posedge clk) disable iff (rst)
        drop |=> ovf_q);

endmodule

// File: rtl/bitfifo_tx.sv
`timescale 1ns/1ps
module bitfifo_tx
    import bitfifo_pkg::*;
#(
    parameter int unsigned DEPTH      = BF_DEPTH,
    parameter int unsigned THR_W      = BF_THR_W,
    parameter int unsigned RATE_W     = BF_RATE_W,
    parameter int unsigned PRESCALE   = BF_PRESCALE,
    parameter int unsigned SLOW_SHIFT = BF_SLOW_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en,
    input  logic              wr_stb,
    input  logic              wr_bit,
    input  logic [THR_W-1:0]  thresh,
    input  logic              tx_en,
    input  logic [RATE_W-1:0] rate_r,
    input  logic              rate_cs,
    input  logic              stat_rd,
    output logic              ser_out,
    output logic              bit_tick,
    output logic              lvl_flag,
    output logic              empty_flag,
    output logic              ovf_flag
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic             run;
    logic             tick;
    logic             full;
    logic [CNT_W-1:0] count;
    bf_op_t           op;

    assign run  = fifo_en && tx_en;
    assign full = (count == CNT_W'(DEPTH));

    always_comb begin
        op.clear = !fifo_en;
        op.push  = fifo_en && wr_stb && !full;
        op.drop  = fifo_en && wr_stb && full;
        op.pop   = tick && (count != '0);
    end

    bitfifo_rate_gen #(
        .PRESCALE   (PRESCALE),
        .RATE_W     (RATE_W),
        .SLOW_SHIFT (SLOW_SHIFT)
    ) u_rate (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .rate_r  (rate_r),
        .rate_cs (rate_cs),
        .tick    (tick)
    );

    bitfifo_store #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W),
        .PTR_W (PTR_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .wr_bit  (wr_bit),
        .count   (count),
        .ser_out (ser_out)
    );

    bitfifo_flags #(
        .CNT_W (CNT_W),
        .THR_W (THR_W)
    ) u_flags (
        .clk        (clk),
        .rst        (rst),
        .count      (count),
        .thresh     (thresh),
        .drop       (op.drop),
        .stat_rd    (stat_rd),
        .lvl_flag   (lvl_flag),
        .empty_flag (empty_flag),
        .ovf_flag   (ovf_flag)
    );

    assign bit_tick = tick;

    // R4: a write while full never raises the count
    a_r4_no_grow: assert property (@(posedge clk) disable iff (rst)
        (full && fifo_en) |=> (count <= CNT_W'(DEPTH)) && !(count == '0 && !tick && fifo_en && $past(!tick)));

endmodule

// File: tb/bitfifo_tx_test.sv
`timescale 1ns/1ps
module bitfifo_tx_test;

    logic       clk = 1'b0;
    logic       rst, fifo_en, wr_stb, wr_bit, tx_en, rate_cs, stat_rd;
    logic [5:0] thresh;
    logic [6:0] rate_r;
    logic       ser_out, bit_tick, lvl_flag, empty_flag, ovf_flag;

    int     errs = 0;
    int     checks = 0;
    int     ntick = 0;
    int     coinc = 0;
    bit     mon = 0;
    bit     done = 0;
    longint cyc = 0;
    longint rc = 0;
    longint last_t = 0;
    bit     have_last = 0;
    bit     q[$];
    logic   m_out = 1'b0;
    logic   m_ovf = 1'b0;

    always #4 clk = ~clk;

    bitfifo_tx uut (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .wr_stb(wr_stb), .wr_bit(wr_bit),
        .thresh(thresh), .tx_en(tx_en), .rate_r(rate_r), .rate_cs(rate_cs),
        .stat_rd(stat_rd), .ser_out(ser_out), .bit_tick(bit_tick),
        .lvl_flag(lvl_flag), .empty_flag(empty_flag), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic b);
        wr_stb = 1'b1;
        wr_bit = b;
        step();
        wr_stb = 1'b0;
    endtask

    task automatic finish_all();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    function automatic logic pat(input int i);
        return ((i * 5 + 3) % 7) < 3;
    endfunction

    // Requirement-level model, advanced at every rising edge
    always @(posedge clk) begin
        int     sz;
        bit     run;
        longint per;
        cyc++;
        if (rst) begin
            q.delete();
            m_out = 1'b0;
            m_ovf = 1'b0;
            rc = 0;
            have_last = 0;
        end else begin
            sz  = q.size();
            run = fifo_en && tx_en;
            per = longint'(29) * (longint'(rate_r) + 1) * (rate_cs ? 8 : 1);
            if (bit_tick && !run)
                chk("R8 tick while stopped", bit_tick, 1'b0);
            if (run) rc++;
            else begin
                rc = 0;
                have_last = 0;
            end
            if (bit_tick && run) begin
                if (have_last) chk_int("R8 tick spacing", cyc - last_t, per);
                else           chk_int("R8 first tick latency", rc, per);
                last_t = cyc;
                have_last = 1;
                ntick++;
            end
            if (!fifo_en) q.delete();
            else begin
                if (bit_tick && sz > 0 && wr_stb && sz < 64) coinc++;
                if (bit_tick && sz > 0) m_out = q.pop_front();
                if (wr_stb && sz < 64) q.push_back(wr_bit);
            end
            if (fifo_en && wr_stb && sz == 64) m_ovf = 1'b1;
            else if (stat_rd)                  m_ovf = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (!rst && mon) begin
            chk("R2 R10 serial output vs queue model", ser_out, m_out);
            chk("R7 empty vs queue model", empty_flag, q.size() == 0);
            chk("R6 level vs queue model", lvl_flag, q.size() <= int'(thresh));
            chk("R5 overflow vs model", ovf_flag, m_ovf);
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL all requirements: watchdog actual=timeout expected=completion");
        finish_all();
    end

    initial begin
        int n0;
        int need;
        rst = 1'b1; fifo_en = 1'b0; wr_stb = 1'b0; wr_bit = 1'b0; tx_en = 1'b0;
        rate_cs = 1'b0; stat_rd = 1'b0; thresh = 6'd0; rate_r = 7'd0;
        repeat (3) step();
        rst = 1'b0;
        step();
        mon = 1;

        // R1 reset state
        chk("R1 empty after reset", empty_flag, 1'b1);
        chk("R1 level after reset", lvl_flag, 1'b1);
        chk("R1 overflow after reset", ovf_flag, 1'b0);
        chk("R1 serial after reset", ser_out, 1'b0);
        chk("R1 no tick after reset", bit_tick, 1'b0);

        // R6 / R7: exhaustive threshold sweep over every fill level
        fifo_en = 1'b1;
        step();
        for (int k = 0; k <= 64; k++) begin
            if (k > 0) wr(pat(k - 1));
            chk("R7 empty during fill", empty_flag, k == 0);
            for (int t = 0; t < 64; t++) begin
                thresh = 6'(t);
                step();
                chk("R6 level flag sweep", lvl_flag, k <= t);
            end
        end
        thresh = 6'd10;

        // R4 / R5 overflow
        wr(~pat(0));
        chk("R4 overflow on write while full", ovf_flag, 1'b1);
        wr_stb = 1'b1; wr_bit = 1'b1; stat_rd = 1'b1;
        step();
        wr_stb = 1'b0; stat_rd = 1'b0;
        chk("R5 overflow set beats read", ovf_flag, 1'b1);
        step();
        chk("R5 overflow sticky", ovf_flag, 1'b1);
        stat_rd = 1'b1;
        step();
        stat_rd = 1'b0;
        chk("R5 overflow cleared by read", ovf_flag, 1'b0);

        // R2 drain order at R=0, slow range off
        rate_r = 7'd0; rate_cs = 1'b0;
        tx_en = 1'b1;
        for (int i = 0; i < 64; i++) begin
            while (!bit_tick) step();
            step();
            chk("R2 bit order on drain", ser_out, pat(i));
        end
        chk("R4 dropped writes not stored", empty_flag, 1'b1);
        for (int i = 0; i < 2; i++) begin
            while (!bit_tick) step();
            step();
            chk("R9 output held when empty", ser_out, pat(63));
        end
        tx_en = 1'b0;
        step();

        // R3 discard and ignore
        for (int i = 0; i < 10; i++) wr(1'b1);
        chk("R3 bits stored before clear", empty_flag, 1'b0);
        fifo_en = 1'b0;
        step();
        chk("R3 contents discarded", empty_flag, 1'b1);
        wr(1'b1);
        chk("R3 write ignored while disabled", empty_flag, 1'b1);
        fifo_en = 1'b1;
        step();
        chk("R3 still empty on re-enable", empty_flag, 1'b1);

        // R10 streaming with coincident writes and ticks
        tx_en = 1'b1;
        wr_stb = 1'b1;
        for (int i = 0; i < 300; i++) begin
            wr_bit = pat(i + 11);
            step();
        end
        wr_stb = 1'b0;
        stat_rd = 1'b1;
        step();
        stat_rd = 1'b0;
        repeat (64 * 29 + 60) step();
        chk("R10 coincident push and pop exercised", coinc > 0, 1'b1);
        chk("R10 stream fully drained", empty_flag, 1'b1);
        tx_en = 1'b0;
        step();

        // R8 rate sweep
        for (int c = 0; c < 7; c++) begin
            case (c)
                0: begin rate_r = 7'd0;   rate_cs = 1'b0; end
                1: begin rate_r = 7'd1;   rate_cs = 1'b0; end
                2: begin rate_r = 7'd5;   rate_cs = 1'b1; end
                3: begin rate_r = 7'd19;  rate_cs = 1'b0; end
                4: begin rate_r = 7'd127; rate_cs = 1'b0; end
                5: begin rate_r = 7'd2;   rate_cs = 1'b1; end
                default: begin rate_r = 7'd127; rate_cs = 1'b1; end
            endcase
            need = (c == 6) ? 2 : 3;
            n0 = ntick;
            tx_en = 1'b1;
            while (ntick < n0 + need) step();
            tx_en = 1'b0;
            step();
            step();
            chk_int("R8 tick count per setting", ntick - n0, need);
        end

        finish_all();
    end

endmodule